// File: doc/BRIEF.md
# Windowed Pixel Transfer Engine

This block takes a stream of 16-bit words arriving on a display data port and places their bytes, as pixels, into a rectangular window of a byte-addressed frame buffer. The window's corners, the input pixel format, the data source code and the panel width are held in a small byte-wide configuration register file. A transfer is armed either by writing the source-select register or, when no transfer is in progress, by the first data word itself. At arm time the block checks the setup, computes the transfer length in words from the bytes-per-pixel of the format and the window size, and latches everything the transfer needs.

Each accepted word writes two bytes through two byte lanes, each with its own address, walking the window row by row from its top-left corner with a line stride set by the panel width. When the last word lands the block pulses a completion flag and widens a dirty rectangle that covers every window completed since the last display refresh.

Top module: `pixwin_fill`

## Requirements
- R1: Configuration register indices: 0/1 X start low byte / upper 2 bits, 2/3 Y start, 4/5 X end, 6/7 Y end (each coordinate 10 bits, low 8 bits from the even index, bits 9:8 from bits 1:0 of the odd index), 8 format code (bits 3:0), 9 source code (bits 2:0; a write also attempts to arm), 10 panel width in units of 8 pixels. After reset all coordinates are 0, format is 3, source is 0, panel width is 1.
- R2: Bytes per pixel by format code: 1 gives 2, 2 and 3 give 3, 6 and 7 give 4; every other code gives 0 and makes arming fail.
- R3: A transfer lasts floor(bpp × width × height / 2) words, with width = Xend − Xstart + 1 and height = Yend − Ystart + 1; busy is high exactly while words remain, and is low after reset.
- R4: Arming fails when the source code exceeds 3, when bytes per pixel is 0, or when an end coordinate is below its start; a failed source-select write leaves any transfer in progress untouched, a successful one restarts the count from the full length even mid-transfer, and a data word in the same cycle as any source-select write is dropped.
- R5: A data word arriving with no transfer in progress attempts to arm using the stored source code; on success it is the first word of the new transfer, on failure it is dropped with no frame buffer write and busy stays low.
- R6: Stream byte i (byte 0 is the low byte of the first word, byte 1 its high byte) goes to address (Ystart + r) × S + Xstart × bpp + c, where r = i / (width × bpp), c = i mod (width × bpp) and S = panel width × 8 × bpp; both bytes of a word are written together in the cycle after the word, low byte on the low lane.
- R7: Window, format and panel width are latched at arm; configuration writes during a transfer do not change where its remaining words land.
- R8: Done is a one-cycle pulse in the cycle after the last word of a transfer, with busy low in that cycle.
- R9: The dirty rectangle is the minimum of completed window start corners and the maximum of start + size, as 11-bit values; the empty rectangle (X0 = Y0 = 2047, X1 = Y1 = 0) holds after reset and after a refresh pulse.
- R10: A refresh pulse in the same cycle as a window completion leaves the dirty rectangle equal to that window alone.
- R11: When bpp × width × height is odd, the final byte is not transferred and the transfer still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| dp_valid | input | 1 | Data-port word strobe |
| dp_data | input | 16 | Data-port word |
| refresh_clr | input | 1 | Display refresh pulse, empties the dirty rectangle |
| busy | output | 1 | Words remain in the current transfer |
| done | output | 1 | One-cycle completion pulse |
| fb_we | output | 1 | Frame buffer write strobe for both lanes |
| fb_addr_lo | output | FB_AW (24) | Byte address for the low lane |
| fb_addr_hi | output | FB_AW (24) | Byte address for the high lane |
| fb_wdata | output | 16 | Lane data, low lane in bits 7:0 |
| dirty_x0 | output | CW+1 (11) | Dirty rectangle left edge |
| dirty_y0 | output | CW+1 (11) | Dirty rectangle top edge |
| dirty_x1 | output | CW+1 (11) | Dirty rectangle right edge (exclusive) |
| dirty_y1 | output | CW+1 (11) | Dirty rectangle bottom edge (exclusive) |

## Verification
The assertions watch, on every cycle, the relation between busy and done, that frame buffer writes only follow accepted words, that busy only rises in response to an input, and that the dirty edges move only outward between refresh pulses. Where each byte lands, the exact word count per format, the rejection rules, the restart on re-arm and the latching of the window against later register writes can only be shown by the bench's transfers, which compare the written frame buffer contents and the dirty rectangle against values computed from the window geometry.

// File: rtl/pixwin_pkg.sv
package pixwin_pkg;

  localparam logic [3:0] RI_XS_LO  = 4'd0;
  localparam logic [3:0] RI_FMT    = 4'd8;
  localparam logic [3:0] RI_SRC    = 4'd9;
  localparam logic [3:0] RI_PANELW = 4'd10;

  localparam logic [3:0] FMT_RESET = 4'd3;
  localparam logic [2:0] SRC_MAX   = 3'd3;

  // Bytes per pixel for each input format code; 0 marks an unsupported code.
  function automatic logic [2:0] fmt_bytes(input logic [3:0] code);
    logic [2:0] b;
    case (code)
      4'd1:          b = 3'd2;
      4'd2, 4'd3:    b = 3'd3;
      4'd6, 4'd7:    b = 3'd4;
      default:       b = 3'd0;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/pixwin_regs.sv
module pixwin_regs
  import pixwin_pkg::*;
#(
  parameter int CW  = 10,
  parameter int PWW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [3:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  output logic [4*CW-1:0] coords,
  output logic [3:0]      fmt,
  output logic [2:0]      src,
  output logic [PWW-1:0]  panel_w,
  output logic            src_wr
);

  localparam int HIW = CW - 8;

  // Four coordinates: X start, Y start, X end, Y end; low byte at even index.
  for (genvar k = 0; k < 4; k++) begin : g_coord
    logic [CW-1:0] c_q, c_d;

    always_comb begin
      c_d = c_q;
      if (cfg_we && cfg_addr == RI_XS_LO + 4'(2 * k))
        c_d[7:0] = cfg_wdata;
      if (cfg_we && cfg_addr == RI_XS_LO + 4'(2 * k + 1))
        c_d[CW-1:8] = cfg_wdata[HIW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_q <= '0;
      else        c_q <= c_d;
    end

    assign coords[k*CW +: CW] = c_q;
  end

  logic [3:0]     fmt_q, fmt_d;
  logic [2:0]     src_q, src_d;
  logic [PWW-1:0] pw_q, pw_d;

  always_comb begin
    fmt_d = fmt_q;
    src_d = src_q;
    pw_d  = pw_q;
    if (cfg_we) begin
      case (cfg_addr)
        RI_FMT:    fmt_d = cfg_wdata[3:0];
        RI_SRC:    src_d = cfg_wdata[2:0];
        RI_PANELW: pw_d  = cfg_wdata[PWW-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_RESET;
      src_q <= '0;
      pw_q  <= PWW'(1);
    end else begin
      fmt_q <= fmt_d;
      src_q <= src_d;
      pw_q  <= pw_d;
    end
  end

  assign fmt     = fmt_q;
  assign src     = src_q;
  assign panel_w = pw_q;
  assign src_wr  = cfg_we && (cfg_addr == RI_SRC);

endmodule

// File: rtl/pixwin_setup.sv
module pixwin_setup
  import pixwin_pkg::*;
#(
  parameter int CW    = 10,
  parameter int PWW   = 8,
  parameter int FB_AW = 24,
  localparam int WW   = CW + 1,
  localparam int RBW  = WW + 3,
  localparam int SW   = PWW + 6,
  localparam int LW   = 2 * WW + 3
) (
  input  logic [4*CW-1:0] coords,
  input  logic [3:0]      fmt,
  input  logic [2:0]      src_code,
  input  logic [PWW-1:0]  panel_w,
  output logic            ok,
  output logic [LW-1:0]   words,
  output logic [FB_AW-1:0] base,
  output logic [SW-1:0]   stride,
  output logic [RBW-1:0]  rowb,
  output logic [CW-1:0]   wx,
  output logic [CW-1:0]   wy,
  output logic [WW-1:0]   ww,
  output logic [WW-1:0]   wh
);

  logic [2:0]    bpp;
  logic [CW-1:0] xs, ys, xe, ye;
  logic [LW-1:0] nbytes;

  always_comb begin
    xs  = coords[0*CW +: CW];
    ys  = coords[1*CW +: CW];
    xe  = coords[2*CW +: CW];
    ye  = coords[3*CW +: CW];
    bpp = fmt_bytes(fmt);

    ww = {1'b0, xe} - {1'b0, xs} + WW'(1);
    wh = {1'b0, ye} - {1'b0, ys} + WW'(1);

    nbytes = LW'(bpp) * LW'(ww) * LW'(wh);
    words  = nbytes >> 1;
    rowb   = RBW'(ww) * RBW'(bpp);
    stride = SW'({panel_w, 3'b000}) * SW'(bpp);
    base   = FB_AW'(ys) * FB_AW'(stride) + FB_AW'(xs) * FB_AW'(bpp);

    wx = xs;
    wy = ys;
    ok = (src_code <= SRC_MAX) && (bpp != 3'd0) && (xe >= xs) && (ye >= ys);
  end

endmodule

// File: rtl/pixwin_walker.sv
module pixwin_walker #(
  parameter int CW    = 10,
  parameter int PWW   = 8,
  parameter int FB_AW = 24,
  localparam int WW   = CW + 1,
  localparam int RBW  = WW + 3,
  localparam int SW   = PWW + 6,
  localparam int LW   = 2 * WW + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_wr,
  input  logic             dp_valid,
  input  logic [15:0]      dp_data,
  input  logic             ok,
  input  logic [LW-1:0]    words,
  input  logic [FB_AW-1:0] base,
  input  logic [SW-1:0]    stride,
  input  logic [RBW-1:0]   rowb,
  input  logic [CW-1:0]    wx,
  input  logic [CW-1:0]    wy,
  input  logic [WW-1:0]    ww,
  input  logic [WW-1:0]    wh,
  output logic             busy,
  output logic             done,
  output logic             fb_we,
  output logic [FB_AW-1:0] fb_addr_lo,
  output logic [FB_AW-1:0] fb_addr_hi,
  output logic [15:0]      fb_wdata,
  output logic             fire,
  output logic [CW-1:0]    fx,
  output logic [CW-1:0]    fy,
  output logic [WW-1:0]    fw,
  output logic [WW-1:0]    fh
);

  logic [LW-1:0]    cnt_q, cnt_d;
  logic [FB_AW-1:0] base_q, base_d;
  logic [RBW-1:0]   colb_q, colb_d;
  logic [RBW-1:0]   rowb_q, rowb_d;
  logic [SW-1:0]    stride_q, stride_d;
  logic [CW-1:0]    wx_q, wx_d, wy_q, wy_d;
  logic [WW-1:0]    ww_q, ww_d, wh_q, wh_d;
  logic             done_q, done_d, we_q, we_d;
  logic [FB_AW-1:0] alo_q, alo_d, ahi_q, ahi_d;
  logic [15:0]      wd_q, wd_d;

  logic             arm_src, fresh, accept;
  logic [LW-1:0]    e_cnt;
  logic [FB_AW-1:0] e_base, base1, base2;
  logic [RBW-1:0]   e_colb, e_rowb, colb1, colb2;
  logic [SW-1:0]    e_stride;
  logic             wrap1, wrap2;

  // Effective transfer state: freshly computed when a data word arms, latched otherwise.
  always_comb begin
    arm_src = src_wr && ok;
    fresh   = dp_valid && !src_wr && (cnt_q == '0) && ok;
    accept  = dp_valid && !src_wr && ((cnt_q != '0) || ok);

    e_cnt    = fresh ? words  : cnt_q;
    e_base   = fresh ? base   : base_q;
    e_colb   = fresh ? '0     : colb_q;
    e_rowb   = fresh ? rowb   : rowb_q;
    e_stride = fresh ? stride : stride_q;
    fx       = fresh ? wx     : wx_q;
    fy       = fresh ? wy     : wy_q;
    fw       = fresh ? ww     : ww_q;
    fh       = fresh ? wh     : wh_q;

    wrap1 = (e_colb + RBW'(1)) == e_rowb;
    colb1 = wrap1 ? '0 : e_colb + RBW'(1);
    base1 = wrap1 ? e_base + FB_AW'(e_stride) : e_base;
    wrap2 = (colb1 + RBW'(1)) == e_rowb;
    colb2 = wrap2 ? '0 : colb1 + RBW'(1);
    base2 = wrap2 ? base1 + FB_AW'(e_stride) : base1;

    fire = accept && (e_cnt == LW'(1));
  end

  always_comb begin
    cnt_d    = cnt_q;
    base_d   = base_q;
    colb_d   = colb_q;
    rowb_d   = rowb_q;
    stride_d = stride_q;
    wx_d     = wx_q;
    wy_d     = wy_q;
    ww_d     = ww_q;
    wh_d     = wh_q;
    alo_d    = alo_q;
    ahi_d    = ahi_q;
    wd_d     = wd_q;
    we_d     = 1'b0;
    done_d   = 1'b0;
    if (arm_src) begin
      cnt_d    = words;
      base_d   = base;
      colb_d   = '0;
      rowb_d   = rowb;
      stride_d = stride;
      wx_d     = wx;
      wy_d     = wy;
      ww_d     = ww;
      wh_d     = wh;
    end else if (accept) begin
      cnt_d    = e_cnt - LW'(1);
      base_d   = base2;
      colb_d   = colb2;
      rowb_d   = e_rowb;
      stride_d = e_stride;
      wx_d     = fx;
      wy_d     = fy;
      ww_d     = fw;
      wh_d     = fh;
      we_d     = 1'b1;
      alo_d    = e_base + FB_AW'(e_colb);
      ahi_d    = base1 + FB_AW'(colb1);
      wd_d     = dp_data;
      done_d   = fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      base_q   <= '0;
      colb_q   <= '0;
      rowb_q   <= '0;
      stride_q <= '0;
      wx_q     <= '0;
      wy_q     <= '0;
      ww_q     <= '0;
      wh_q     <= '0;
      alo_q    <= '0;
      ahi_q    <= '0;
      wd_q     <= '0;
      we_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      base_q   <= base_d;
      colb_q   <= colb_d;
      rowb_q   <= rowb_d;
      stride_q <= stride_d;
      wx_q     <= wx_d;
      wy_q     <= wy_d;
      ww_q     <= ww_d;
      wh_q     <= wh_d;
      alo_q    <= alo_d;
      ahi_q    <= ahi_d;
      wd_q     <= wd_d;
      we_q     <= we_d;
      done_q   <= done_d;
    end
  end

  assign busy       = (cnt_q != '0);
  assign done       = done_q;
  assign fb_we      = we_q;
  assign fb_addr_lo = alo_q;
  assign fb_addr_hi = ahi_q;
  assign fb_wdata   = wd_q;

endmodule

// File: rtl/pixwin_dirty.sv
module pixwin_dirty #(
  parameter int CW  = 10,
  localparam int DW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fire,
  input  logic [CW-1:0] fx,
  input  logic [CW-1:0] fy,
  input  logic [DW-1:0] fw,
  input  logic [DW-1:0] fh,
  output logic [DW-1:0] x0,
  output logic [DW-1:0] y0,
  output logic [DW-1:0] x1,
  output logic [DW-1:0] y1
);

  logic [DW-1:0] x0_q, y0_q, x1_q, y1_q;
  logic [DW-1:0] x0_d, y0_d, x1_d, y1_d;
  logic [DW-1:0] ex, ey;

  always_comb begin
    // A refresh empties the rectangle first; a completing window then merges in.
    x0_d = clr ? '1 : x0_q;
    y0_d = clr ? '1 : y0_q;
    x1_d = clr ? '0 : x1_q;
    y1_d = clr ? '0 : y1_q;
    ex   = DW'(fx) + fw;
    ey   = DW'(fy) + fh;
    if (fire) begin
      if (DW'(fx) < x0_d) x0_d = DW'(fx);
      if (DW'(fy) < y0_d) y0_d = DW'(fy);
      if (ex > x1_d)      x1_d = ex;
      if (ey > y1_d)      y1_d = ey;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0_q <= '1;
      y0_q <= '1;
      x1_q <= '0;
      y1_q <= '0;
    end else begin
      x0_q <= x0_d;
      y0_q <= y0_d;
      x1_q <= x1_d;
      y1_q <= y1_d;
    end
  end

  assign x0 = x0_q;
  assign y0 = y0_q;
  assign x1 = x1_q;
  assign y1 = y1_q;

endmodule

// File: rtl/pixwin_fill.sv
module pixwin_fill #(
  parameter int CW    = 10,
  parameter int PWW   = 8,
  parameter int FB_AW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic             dp_valid,
  input  logic [15:0]      dp_data,
  input  logic             refresh_clr,
  output logic             busy,
  output logic             done,
  output logic             fb_we,
  output logic [FB_AW-1:0] fb_addr_lo,
  output logic [FB_AW-1:0] fb_addr_hi,
  output logic [15:0]      fb_wdata,
  output logic [CW:0]      dirty_x0,
  output logic [CW:0]      dirty_y0,
  output logic [CW:0]      dirty_x1,
  output logic [CW:0]      dirty_y1
);

  localparam int WW  = CW + 1;
  localparam int RBW = WW + 3;
  localparam int SW  = PWW + 6;
  localparam int LW  = 2 * WW + 3;

  // Reset asserts at once and is released on a clock edge.
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic [4*CW-1:0]  coords;
  logic [3:0]       fmt;
  logic [2:0]       src_q, src_code;
  logic [PWW-1:0]   panel_w;
  logic             src_wr, ok, fire;
  logic [LW-1:0]    words;
  logic [FB_AW-1:0] base;
  logic [SW-1:0]    stride;
  logic [RBW-1:0]   rowb;
  logic [CW-1:0]    wx, wy, fx, fy;
  logic [WW-1:0]    ww, wh, fw, fh;

  pixwin_regs #(.CW(CW), .PWW(PWW)) u_regs (
    .clk(clk), .rst_n(rst_s), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .coords(coords), .fmt(fmt), .src(src_q),
    .panel_w(panel_w), .src_wr(src_wr)
  );

  // A source-select write is checked against the code being written.
  assign src_code = src_wr ? cfg_wdata[2:0] : src_q;

  pixwin_setup #(.CW(CW), .PWW(PWW), .FB_AW(FB_AW)) u_setup (
    .coords(coords), .fmt(fmt), .src_code(src_code), .panel_w(panel_w),
    .ok(ok), .words(words), .base(base), .stride(stride), .rowb(rowb),
    .wx(wx), .wy(wy), .ww(ww), .wh(wh)
  );

  pixwin_walker #(.CW(CW), .PWW(PWW), .FB_AW(FB_AW)) u_walker (
    .clk(clk), .rst_n(rst_s), .src_wr(src_wr), .dp_valid(dp_valid),
    .dp_data(dp_data), .ok(ok), .words(words), .base(base),
    .stride(stride), .rowb(rowb), .wx(wx), .wy(wy), .ww(ww), .wh(wh),
    .busy(busy), .done(done), .fb_we(fb_we), .fb_addr_lo(fb_addr_lo),
    .fb_addr_hi(fb_addr_hi), .fb_wdata(fb_wdata), .fire(fire),
    .fx(fx), .fy(fy), .fw(fw), .fh(fh)
  );

  pixwin_dirty #(.CW(CW)) u_dirty (
    .clk(clk), .rst_n(rst_s), .clr(refresh_clr), .fire(fire),
    .fx(fx), .fy(fy), .fw(fw), .fh(fh),
    .x0(dirty_x0), .y0(dirty_y0), .x1(dirty_x1), .y1(dirty_y1)
  );

endmodule

// File: rtl/pixwin_fill_chk.sv
module pixwin_fill_chk #(
  parameter int CW = 10
) (
  input logic      clk,
  input logic      rst_n,
  input logic      cfg_we,
  input logic      dp_valid,
  input logic      refresh_clr,
  input logic      busy,
  input logic      done,
  input logic      fb_we,
  input logic [CW:0] dirty_x0,
  input logic [CW:0] dirty_y0,
  input logic [CW:0] dirty_x1,
  input logic [CW:0] dirty_y1
);

  // R8: the completion pulse never overlaps remaining words
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: busy only drops when a transfer completes
  a_r8_busy_falls_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R6: a frame buffer write always follows an accepted data word
  a_r6_we_follows_word: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> $past(dp_valid));

  // R4: busy only rises in response to a register write or a data word
  a_r4_busy_rises_on_input: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_we || dp_valid));

  // R9: between refresh pulses the dirty rectangle only grows
  a_r9_left_top_shrink_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(refresh_clr) |-> (dirty_x0 <= $past(dirty_x0)) && (dirty_y0 <= $past(dirty_y0)));

  a_r9_right_bottom_grow_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(refresh_clr) |-> (dirty_x1 >= $past(dirty_x1)) && (dirty_y1 >= $past(dirty_y1)));

endmodule

bind pixwin_fill pixwin_fill_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .dp_valid(dp_valid),
  .refresh_clr(refresh_clr), .busy(busy), .done(done), .fb_we(fb_we),
  .dirty_x0(dirty_x0), .dirty_y0(dirty_y0), .dirty_x1(dirty_x1),
  .dirty_y1(dirty_y1)
);

// File: tb/pixwin_fill_bench.sv
`timescale 1ns/1ps
module pixwin_fill_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        dp_valid = 1'b0;
  logic [15:0] dp_data = '0;
  logic        refresh_clr = 1'b0;
  logic        busy, done, fb_we;
  logic [23:0] fb_addr_lo, fb_addr_hi;
  logic [15:0] fb_wdata;
  logic [10:0] dirty_x0, dirty_y0, dirty_x1, dirty_y1;

  pixwin_fill u_pixwin_fill (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dp_valid(dp_valid), .dp_data(dp_data),
    .refresh_clr(refresh_clr), .busy(busy), .done(done), .fb_we(fb_we),
    .fb_addr_lo(fb_addr_lo), .fb_addr_hi(fb_addr_hi), .fb_wdata(fb_wdata),
    .dirty_x0(dirty_x0), .dirty_y0(dirty_y0), .dirty_x1(dirty_x1),
    .dirty_y1(dirty_y1)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int done_cnt = 0;
  logic [7:0] mem [int];
  logic [15:0] wd [0:511];
  int ex0 = 2047, ey0 = 2047, ex1 = 0, ey1 = 0;

  always @(negedge clk) begin
    if (rst_n && fb_we) begin
      mem[int'(fb_addr_lo)] = fb_wdata[7:0];
      mem[int'(fb_addr_hi)] = fb_wdata[15:8];
      wr_cnt++;
    end
    if (rst_n && done) done_cnt++;
  end

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bpp_of(int f);
    case (f)
      1: return 2;
      2, 3: return 3;
      6, 7: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic cfg(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_wdata = d[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic set_win(int xs, int ys, int xe, int ye);
    cfg(0, xs & 255); cfg(1, xs >> 8);
    cfg(2, ys & 255); cfg(3, ys >> 8);
    cfg(4, xe & 255); cfg(5, xe >> 8);
    cfg(6, ye & 255); cfg(7, ye >> 8);
  endtask

  task automatic word(int d, bit clr = 1'b0);
    @(negedge clk);
    dp_valid = 1'b1; dp_data = d[15:0]; refresh_clr = clr;
    @(negedge clk);
    dp_valid = 1'b0; refresh_clr = 1'b0;
    #1;
  endtask

  task automatic refresh();
    @(negedge clk);
    refresh_clr = 1'b1;
    @(negedge clk);
    refresh_clr = 1'b0;
    #1;
    ex0 = 2047; ey0 = 2047; ex1 = 0; ey1 = 0;
  endtask

  task automatic check_dirty(string req);
    check_eq(req, "dirty x0", int'(dirty_x0), ex0);
    check_eq(req, "dirty y0", int'(dirty_y0), ey0);
    check_eq(req, "dirty x1", int'(dirty_x1), ex1);
    check_eq(req, "dirty y1", int'(dirty_y1), ey1);
  endtask

  // Full transfer with frame buffer and dirty rectangle comparison.
  task automatic run_window(string req, int xs, int ys, int w, int h, int fmt,
                            int pw, bit by_src, bit clr_last);
    int bpp, nb, nw, d0, w0, mism, rowbytes, stride, first_a, first_e, first_x;
    bpp = bpp_of(fmt);
    nb = bpp * w * h;
    nw = nb / 2;
    cfg(8, fmt);
    cfg(10, pw);
    set_win(xs, ys, xs + w - 1, ys + h - 1);
    mem.delete();
    d0 = done_cnt;
    w0 = wr_cnt;
    if (by_src) begin
      cfg(9, 0);
      check_eq({req, " R4"}, "busy after source arm", int'(busy), 1);
    end
    for (int i = 0; i < nw; i++) wd[i] = 16'($urandom);
    for (int i = 0; i < nw; i++) word(int'(wd[i]), clr_last && (i == nw - 1));
    check_eq({req, " R8"}, "done pulse at last word", int'(done), 1);
    check_eq({req, " R3"}, "busy after last word", int'(busy), 0);
    check_eq({req, " R3"}, "words written", wr_cnt - w0, nw);
    rowbytes = w * bpp;
    stride = pw * 8 * bpp;
    mism = 0; first_a = -1; first_e = 0; first_x = 0;
    for (int i = 0; i < 2 * nw; i++) begin
      int a, e, r, c;
      r = i / rowbytes;
      c = i % rowbytes;
      a = (ys + r) * stride + xs * bpp + c;
      e = (i % 2 == 0) ? int'(wd[i / 2][7:0]) : int'(wd[i / 2][15:8]);
      if (!mem.exists(a)) begin
        mism++;
        if (first_a < 0) begin first_a = a; first_e = e; first_x = -1; end
      end else if (int'(mem[a]) != e) begin
        mism++;
        if (first_a < 0) begin first_a = a; first_e = e; first_x = int'(mem[a]); end
      end
    end
    if (mism != 0)
      $display("  byte at %0d holds %0d, expected %0d", first_a, first_x, first_e);
    check_eq({req, " R6"}, "mismatched bytes", mism, 0);
    check_eq({req, " R6"}, "distinct bytes written", mem.num(), 2 * nw);
    @(negedge clk); #1;
    check_eq({req, " R8"}, "done one cycle only", int'(done), 0);
    check_eq({req, " R8"}, "done pulses", done_cnt - d0, 1);
    if (clr_last) begin ex0 = 2047; ey0 = 2047; ex1 = 0; ey1 = 0; end
    if (xs < ex0) ex0 = xs;
    if (ys < ey0) ey0 = ys;
    if (xs + w > ex1) ex1 = xs + w;
    if (ys + h > ey1) ey1 = ys + h;
    check_dirty(clr_last ? "R10" : "R9");
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w0, d0;
    void'($urandom(32'h5eed_0f11));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // Reset state
    check_eq("R3", "busy after reset", int'(busy), 0);
    check_eq("R8", "done after reset", int'(done), 0);
    check_eq("R6", "fb_we after reset", int'(fb_we), 0);
    check_dirty("R9");

    // R1: reset format 3 (3 bytes) and panel width 1, window 0..0: one word via data arm
    run_window("R1 reset regs", 0, 0, 1, 1, 3, 1, 1'b0, 1'b0);

    // R1: coordinates above 255 use the upper bits register
    run_window("R1 high coords", 700, 300, 3, 2, 1, 100, 1'b1, 1'b0);

    // R11: odd byte count, final byte dropped
    run_window("R11 odd bytes", 5, 2, 1, 1, 2, 4, 1'b1, 1'b0);
    run_window("R11 odd 3x3", 9, 9, 3, 3, 3, 4, 1'b0, 1'b0);

    // R2: each supported format
    run_window("R2 fmt1", 4, 4, 4, 3, 1, 8, 1'b1, 1'b0);
    run_window("R2 fmt6", 1, 7, 2, 4, 6, 8, 1'b0, 1'b0);
    run_window("R2 fmt7", 12, 3, 5, 2, 7, 8, 1'b1, 1'b0);

    // R10: refresh coincides with completion
    run_window("R10 clr at end", 20, 30, 2, 2, 1, 8, 1'b1, 1'b1);

    // Random windows
    for (int k = 0; k < 10; k++) begin
      int fl [5] = '{1, 2, 3, 6, 7};
      run_window("R6 random", int'($urandom % 300), int'($urandom % 600),
                 1 + int'($urandom % 5), 1 + int'($urandom % 5),
                 fl[$urandom % 5], 40 + int'($urandom % 10),
                 bit'($urandom % 2), 1'b0);
    end

    // R9: refresh alone empties the rectangle
    refresh();
    check_dirty("R9");

    // R2/R4/R5: unsupported format is rejected on both arm paths
    set_win(0, 0, 1, 0);
    cfg(8, 5);
    cfg(9, 0);
    check_eq("R2", "busy after arm with format 5", int'(busy), 0);
    w0 = wr_cnt;
    word(16'h1234);
    check_eq("R5", "writes from word with bad format", wr_cnt - w0, 0);
    check_eq("R5", "busy after dropped word", int'(busy), 0);

    // R4/R5: source code 4 rejected, stored code also blocks data arming
    cfg(8, 1);
    cfg(9, 4);
    check_eq("R4", "busy after source code 4", int'(busy), 0);
    w0 = wr_cnt;
    word(16'h4321);
    check_eq("R5", "writes with stored source 4", wr_cnt - w0, 0);

    // R4: end below start
    set_win(5, 0, 4, 0);
    cfg(9, 0);
    check_eq("R4", "busy with X end below start", int'(busy), 0);
    set_win(0, 6, 0, 5);
    cfg(9, 0);
    check_eq("R4", "busy with Y end below start", int'(busy), 0);

    // R4: failed source write leaves a transfer running
    set_win(0, 0, 1, 0);
    cfg(9, 0);
    d0 = done_cnt;
    word(16'h0001);
    cfg(9, 5);
    check_eq("R4", "busy after failed re-arm", int'(busy), 1);
    word(16'h0002);
    check_eq("R4", "done after failed re-arm", done_cnt - d0, 1);

    // R4: successful re-arm restarts from the full length (3 words)
    set_win(0, 0, 2, 0);
    cfg(9, 0);
    word(16'h0003);
    word(16'h0004);
    cfg(9, 0);
    d0 = done_cnt;
    word(16'h0005);
    word(16'h0006);
    check_eq("R4", "busy two words after restart", int'(busy), 1);
    word(16'h0007);
    check_eq("R4", "done after restarted length", done_cnt - d0, 1);

    // R4: data word in the same cycle as a source write is dropped
    set_win(0, 0, 0, 0);
    cfg(9, 0);
    w0 = wr_cnt;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd9; cfg_wdata = 8'd0;
    dp_valid = 1'b1; dp_data = 16'hbeef;
    @(negedge clk);
    cfg_we = 1'b0; dp_valid = 1'b0;
    #1;
    check_eq("R4", "writes from word beside source write", wr_cnt - w0, 0);
    check_eq("R4", "busy after coinciding write", int'(busy), 1);
    word(16'h0008);
    check_eq("R4", "busy after single word", int'(busy), 0);

    // R7: registers changed mid-transfer do not move the remaining words
    cfg(10, 1);
    set_win(2, 1, 3, 1);
    cfg(9, 0);
    mem.delete();
    word(16'h2211);
    set_win(0, 5, 7, 5);
    cfg(8, 6);
    cfg(10, 9);
    word(16'h4433);
    check_eq("R7", "byte 20", mem.exists(20) ? int'(mem[20]) : -1, 8'h11);
    check_eq("R7", "byte 21", mem.exists(21) ? int'(mem[21]) : -1, 8'h22);
    check_eq("R7", "byte 22", mem.exists(22) ? int'(mem[22]) : -1, 8'h33);
    check_eq("R7", "byte 23", mem.exists(23) ? int'(mem[23]) : -1, 8'h44);
    check_eq("R7", "bytes written", mem.num(), 4);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule